// File: doc/BRIEF.md
# Effective Address Generator

This unit converts an addressing-mode code, a 16-bit operand and the two 8-bit index registers into a 16-bit effective address for a byte-oriented processor core. Direct modes (absolute, absolute indexed, zero page, zero page indexed) are resolved with a single adder and finish one cycle after the request. Pointer modes (indirect, pre-indexed indirect, post-indexed indirect) fetch a little-endian 16-bit pointer through a byte-wide read port before finishing.

The core pulses `start` with the mode, operand and index values valid in the same cycle. It then waits for `done`. `ea` carries the result and holds it until the next completion. `err` pulses together with `done` when the mode code is not defined, or when a pre-indexed pointer would straddle the end of page zero. In both cases no memory read is issued and `ea` is zero. A `start` that arrives while a pointer fetch is in flight is dropped.

Top module: `ea_gen`

## Requirements
- R1: Mode code 0 (absolute) returns the 16-bit operand unchanged, with `done` high in the cycle after the accepted `start`.
- R2: Mode codes 1 and 2 add X or Y, zero-extended, to the 16-bit operand modulo 65536, with `done` in the cycle after `start`.
- R3: Mode code 3 (page zero) returns the low operand byte with the upper byte forced to zero; the upper operand byte is ignored.
- R4: Mode codes 4 and 5 add X or Y to the low operand byte modulo 256, so the result always has a zero upper byte.
- R5: Mode code 6 (indirect) issues exactly two reads on consecutive cycles: the low byte at the operand, then the high byte at the operand plus one modulo 65536. `rd_data` answers one cycle after `rd_en`. The result is {high, low}, and `done` rises four cycles after `start`.
- R6: Mode code 7 (pre-indexed) reads the pointer at page-zero location (low operand byte + X) mod 256 and its successor, and returns that pointer.
- R7: In mode code 7, if that location equals 0xFF, the unit issues no read, pulses `err` and `done` in the cycle after `start`, and returns address zero.
- R8: Mode code 8 (post-indexed) reads the pointer at the low operand byte and at (that byte + 1) mod 256 in page zero. It returns pointer + Y modulo 65536, using the Y value present at `start`.
- R9: Mode codes 9 to 15 pulse `err` with `done` in the cycle after `start`, issue no read, and return address zero.
- R10: A `start` that arrives while a pointer fetch is in progress is ignored. It produces no extra `done` and does not change the pending result.
- R11: After reset, `done`, `err` and `rd_en` are low and `ea` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse; mode, operand and indexes are sampled with it |
| mode | input | 4 | Addressing-mode code |
| operand | input | 16 | Instruction operand; only the low byte is used in page-zero modes |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| rd_en | output | 1 | Pointer byte read request |
| rd_addr | output | 16 | Pointer byte read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal request, valid with `done` |
| ea | output | 16 | Effective address, held until the next completion |

## Verification
The bench uses the default byte width of 8, which gives a 16-bit address. At that width both wrap boundaries can be reached with small directed vectors: page-zero sums crossing 0xFF and absolute sums crossing 0xFFFF. The memory model computes each byte from its address. This lets the bench place a pointer at page-zero location 0x1D whose high byte is 0xFF, so the post-indexed sum really wraps. It also lets the bench read a pointer whose low byte sits at 0xFFFF or at 0x00FF, which exercises the successor-address wrap rule of each pointer mode.

// File: rtl/eag_pkg.sv
// Shared definitions for the effective address generator.
// Assumes a byte-wide memory; mode codes are fixed by the decoder contract.
package eag_pkg;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        AM_ABS    = 4'd0,
        AM_ABS_X  = 4'd1,
        AM_ABS_Y  = 4'd2,
        AM_ZP     = 4'd3,
        AM_ZP_X   = 4'd4,
        AM_ZP_Y   = 4'd5,
        AM_IND    = 4'd6,
        AM_PRE_X  = 4'd7,
        AM_POST_Y = 4'd8
    } am_e;

    typedef enum logic [1:0] {
        IDX_NONE = 2'd0,
        IDX_X    = 2'd1,
        IDX_Y    = 2'd2
    } idx_sel_e;

    typedef struct packed {
        logic     legal;   // mode code is defined
        logic     ptr;     // a pointer fetch is required
        logic     zp;      // location sum wraps inside page zero
        logic     ptr_zp;  // pointer high byte stays in page zero
        logic     post_y;  // Y added after the fetch
        idx_sel_e idx;     // index applied before any fetch
    } am_ctl_t;
endpackage

// File: rtl/eag_mode_decode.sv
// Mode decoder: maps a mode code onto the control fields the datapath uses.
// Purely combinational; undefined codes come out with legal cleared.
module eag_mode_decode
    import eag_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output am_ctl_t           ctl
);
    // Translate the code into the datapath control bundle.
    always_comb begin
        ctl = '{legal: 1'b0, ptr: 1'b0, zp: 1'b0, ptr_zp: 1'b0,
                post_y: 1'b0, idx: IDX_NONE};
        case (mode)
            AM_ABS:    ctl.legal = 1'b1;
            AM_ABS_X:  begin ctl.legal = 1'b1; ctl.idx = IDX_X; end
            AM_ABS_Y:  begin ctl.legal = 1'b1; ctl.idx = IDX_Y; end
            AM_ZP:     begin ctl.legal = 1'b1; ctl.zp = 1'b1; end
            AM_ZP_X:   begin ctl.legal = 1'b1; ctl.zp = 1'b1; ctl.idx = IDX_X; end
            AM_ZP_Y:   begin ctl.legal = 1'b1; ctl.zp = 1'b1; ctl.idx = IDX_Y; end
            AM_IND:    begin ctl.legal = 1'b1; ctl.ptr = 1'b1; end
            AM_PRE_X:  begin
                ctl.legal = 1'b1; ctl.ptr = 1'b1; ctl.zp = 1'b1;
                ctl.ptr_zp = 1'b1; ctl.idx = IDX_X;
            end
            AM_POST_Y: begin
                ctl.legal = 1'b1; ctl.ptr = 1'b1; ctl.zp = 1'b1;
                ctl.ptr_zp = 1'b1; ctl.post_y = 1'b1;
            end
            default:   ctl.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/eag_index_adder.sv
// Index adder: adds a zero-extended index to a base address.
// With page_wrap set, only the low byte is summed and the carry is dropped,
// so the result stays in page zero; otherwise the sum wraps at full width.
module eag_index_adder #(
    parameter  int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DATA_W-1:0] index,
    input  logic              page_wrap,
    output logic [ADDR_W-1:0] sum
);
    logic [DATA_W-1:0] low_sum;
    logic [ADDR_W-1:0] full_sum;

    assign low_sum  = base[DATA_W-1:0] + index;
    assign full_sum = base + {{DATA_W{1'b0}}, index};

    // Choose the wrap rule for this mode.
    always_comb begin
        if (page_wrap) sum = {{DATA_W{1'b0}}, low_sum};
        else           sum = full_sum;
    end
endmodule

// File: rtl/eag_ptr_seq.sv
// Pointer fetch sequencer: reads a little-endian pointer, low byte first.
// Assumes read data returns exactly one cycle after the request. The high
// byte address either wraps at full width or stays inside the page of loc.
module eag_ptr_seq #(
    parameter  int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] loc,
    input  logic              in_page,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              ptr_valid,
    output logic [ADDR_W-1:0] ptr
);
    typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_CAP} seq_e;

    seq_e              st;
    logic [ADDR_W-1:0] loc_q;
    logic              page_q;
    logic [DATA_W-1:0] lo_q;
    logic [ADDR_W-1:0] hi_addr;
    logic [DATA_W-1:0] lo_next;

    assign lo_next = loc_q[DATA_W-1:0] + 1'b1;

    // Successor address under the chosen wrap rule.
    always_comb begin
        if (page_q) hi_addr = {loc_q[ADDR_W-1:DATA_W], lo_next};
        else        hi_addr = loc_q + 1'b1;
    end

    // Drive the read port and present the assembled pointer.
    always_comb begin
        rd_en     = (st == S_LO) || (st == S_HI);
        rd_addr   = (st == S_HI) ? hi_addr : loc_q;
        ptr_valid = (st == S_CAP);
        ptr       = {rd_data, lo_q};
    end

    // Step through request-low, request-high, capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            loc_q  <= '0;
            page_q <= 1'b0;
            lo_q   <= '0;
        end else begin
            case (st)
                S_IDLE: if (go) begin
                    loc_q  <= loc;
                    page_q <= in_page;
                    st     <= S_LO;
                end
                S_LO:    st <= S_HI;
                S_HI: begin
                    lo_q <= rd_data;
                    st   <= S_CAP;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R5: reads come as an adjacent pair, never alone and never three.
    p_read_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |=> rd_en);
    p_read_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && $past(rd_en) |=> !rd_en);
    // R5: the pointer is presented the cycle after the last request.
    p_ptr_after_reads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_valid |-> !rd_en && $past(rd_en));
    // R8: a page-zero pointer high byte never leaves the page of the low byte.
    p_page_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HI) && page_q |->
            rd_addr[ADDR_W-1:DATA_W] == $past(rd_addr[ADDR_W-1:DATA_W]));
endmodule

// File: rtl/ea_gen.sv
// Effective address generator top. Resolves direct modes in one cycle and
// pointer modes through the fetch sequencer. Rejects undefined modes and
// pre-indexed locations that would straddle page zero. Assumes the caller
// holds start for one cycle and waits for done before the next request.
module ea_gen
    import eag_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [ADDR_W-1:0] operand,
    input  logic [DATA_W-1:0] idx_x,
    input  logic [DATA_W-1:0] idx_y,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] ea
);
    am_ctl_t           ctl;
    logic [DATA_W-1:0] pre_idx;
    logic [ADDR_W-1:0] loc;
    logic              busy_q;
    logic              accept;
    logic              bad_wrap;
    logic              fault;
    logic              launch;
    logic              ptr_valid;
    logic [ADDR_W-1:0] ptr;
    logic              post_y_q;
    logic [DATA_W-1:0] y_q;
    logic [DATA_W-1:0] post_idx;
    logic [ADDR_W-1:0] final_addr;
    logic              done_q;
    logic              err_q;
    logic [ADDR_W-1:0] ea_q;

    eag_mode_decode u_dec (
        .mode (mode),
        .ctl  (ctl)
    );

    // Index applied before any pointer fetch.
    always_comb begin
        case (ctl.idx)
            IDX_X:   pre_idx = idx_x;
            IDX_Y:   pre_idx = idx_y;
            default: pre_idx = '0;
        endcase
    end

    eag_index_adder #(.DATA_W(DATA_W)) u_loc_add (
        .base      (operand),
        .index     (pre_idx),
        .page_wrap (ctl.zp),
        .sum       (loc)
    );

    // Request qualification: acceptance, error cases and fetch launch.
    always_comb begin
        accept   = start && !busy_q;
        bad_wrap = ctl.legal && ctl.ptr && (ctl.idx == IDX_X)
                   && (&loc[DATA_W-1:0]);
        fault    = !ctl.legal || bad_wrap;
        launch   = accept && !fault && ctl.ptr;
    end

    eag_ptr_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (launch),
        .loc       (loc),
        .in_page   (ctl.ptr_zp),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .ptr_valid (ptr_valid),
        .ptr       (ptr)
    );

    assign post_idx = post_y_q ? y_q : '0;

    eag_index_adder #(.DATA_W(DATA_W)) u_post_add (
        .base      (ptr),
        .index     (post_idx),
        .page_wrap (1'b0),
        .sum       (final_addr)
    );

    // Result register, completion pulse and busy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            ea_q     <= '0;
            post_y_q <= 1'b0;
            y_q      <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (accept) begin
                if (fault) begin
                    done_q <= 1'b1;
                    err_q  <= 1'b1;
                    ea_q   <= '0;
                end else if (ctl.ptr) begin
                    busy_q   <= 1'b1;
                    post_y_q <= ctl.post_y;
                    y_q      <= idx_y;
                end else begin
                    done_q <= 1'b1;
                    ea_q   <= loc;
                end
            end else if (busy_q && ptr_valid) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                ea_q   <= final_addr;
            end
        end
    end

    assign done = done_q;
    assign err  = err_q;
    assign ea   = ea_q;

    // R1: absolute mode echoes the operand one cycle later.
    p_abs_echo_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy_q && (mode == AM_ABS) |=> done && !err && ea == $past(operand));
    // R4: page-zero modes never produce a nonzero upper byte.
    p_zp_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy_q && (mode == AM_ZP || mode == AM_ZP_X || mode == AM_ZP_Y)
        |=> done && ea[ADDR_W-1:DATA_W] == '0);
    // R7: a rejected request reports a zero address.
    p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done && ea == '0);
    // R9: undefined codes complete at once with an error and no read.
    p_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy_q && (mode > AM_POST_Y) |=> done && err && !rd_en);
    // R10: no completion while a fetch is still outstanding.
    p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !ptr_valid |=> !done);
endmodule

// File: tb/sim_ea_gen.sv
`timescale 1ns/1ps
module sim_ea_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [15:0] operand = '0;
    logic [7:0]  idx_x = '0;
    logic [7:0]  idx_y = '0;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data = '0;
    logic        done;
    logic        err;
    logic [15:0] ea;

    int n_checks = 0;
    int n_fails  = 0;
    int rd_total = 0;
    logic [15:0] rd_prev = '0;
    logic [15:0] rd_last = '0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ea_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .operand(operand),
        .idx_x(idx_x), .idx_y(idx_y), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .done(done), .err(err), .ea(ea)
    );

    // Memory content derived from the address.
    function automatic logic [7:0] memf(input logic [15:0] a);
        logic [7:0] t;
        t = a[7:0] * 8'd3;
        return t ^ a[15:8] ^ 8'hA5;
    endfunction

    // One-cycle read latency memory and a read monitor.
    always @(posedge clk) begin
        if (rd_en) begin
            rd_data  <= memf(rd_addr);
            rd_total <= rd_total + 1;
            rd_prev  <= rd_last;
            rd_last  <= rd_addr;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Issue one request, measure latency, check the result and reads.
    task automatic run_case(input string req, input logic [3:0] md,
                            input logic [15:0] op, input logic [7:0] x,
                            input logic [7:0] y, input logic [15:0] exp_ea,
                            input logic exp_err, input int exp_lat,
                            input int exp_rd, input logic [15:0] exp_a0,
                            input logic [15:0] exp_a1);
        int lat;
        int rd0;
        @(negedge clk);
        rd0 = rd_total;
        mode = md; operand = op; idx_x = x; idx_y = y; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        check(req, "latency", lat, exp_lat);
        check(req, "address", {16'h0, ea}, {16'h0, exp_ea});
        check(req, "error", {31'h0, err}, {31'h0, exp_err});
        check(req, "read count", rd_total - rd0, exp_rd);
        if (exp_rd == 2) begin
            check(req, "low read addr", {16'h0, rd_prev}, {16'h0, exp_a0});
            check(req, "high read addr", {16'h0, rd_last}, {16'h0, exp_a1});
        end
    endtask

    task automatic t_reset;
        // R11
        check("R11", "done", {31'h0, done}, 32'h0);
        check("R11", "err", {31'h0, err}, 32'h0);
        check("R11", "rd_en", {31'h0, rd_en}, 32'h0);
        check("R11", "ea", {16'h0, ea}, 32'h0);
    endtask

    task automatic t_absolute;
        run_case("R1", 4'd0, 16'h1234, 8'h11, 8'h22, 16'h1234, 1'b0, 1, 0, 0, 0);
        run_case("R1", 4'd0, 16'hFFFF, 8'hFF, 8'hFF, 16'hFFFF, 1'b0, 1, 0, 0, 0);
    endtask

    task automatic t_abs_indexed;
        run_case("R2", 4'd1, 16'hFFF0, 8'h20, 8'h77, 16'h0010, 1'b0, 1, 0, 0, 0);
        run_case("R2", 4'd2, 16'h10F0, 8'h99, 8'h30, 16'h1120, 1'b0, 1, 0, 0, 0);
    endtask

    task automatic t_zero_page;
        run_case("R3", 4'd3, 16'hAB12, 8'h40, 8'h50, 16'h0012, 1'b0, 1, 0, 0, 0);
    endtask

    task automatic t_zp_indexed;
        run_case("R4", 4'd4, 16'h33F0, 8'h20, 8'h01, 16'h0010, 1'b0, 1, 0, 0, 0);
        run_case("R4", 4'd5, 16'h0080, 8'hEE, 8'h05, 16'h0085, 1'b0, 1, 0, 0, 0);
        run_case("R4", 4'd5, 16'h00FF, 8'h00, 8'hFF, 16'h00FE, 1'b0, 1, 0, 0, 0);
    endtask

    task automatic t_indirect;
        run_case("R5", 4'd6, 16'h12FF, 8'h05, 8'h06,
                 {memf(16'h1300), memf(16'h12FF)}, 1'b0, 4, 2, 16'h12FF, 16'h1300);
        run_case("R5", 4'd6, 16'hFFFF, 8'h05, 8'h06,
                 {memf(16'h0000), memf(16'hFFFF)}, 1'b0, 4, 2, 16'hFFFF, 16'h0000);
    endtask

    task automatic t_pre_indexed;
        run_case("R6", 4'd7, 16'h55F0, 8'h20, 8'h09,
                 {memf(16'h0011), memf(16'h0010)}, 1'b0, 4, 2, 16'h0010, 16'h0011);
    endtask

    task automatic t_pre_wrap_err;
        run_case("R7", 4'd7, 16'h0080, 8'h7F, 8'h00, 16'h0000, 1'b1, 1, 0, 0, 0);
    endtask

    task automatic t_post_indexed;
        logic [15:0] p;
        p = {memf(16'h0000), memf(16'h00FF)} + 16'h00C0;
        run_case("R8", 4'd8, 16'h77FF, 8'h33, 8'hC0, p, 1'b0, 4, 2, 16'h00FF, 16'h0000);
        // Pointer high byte is 0xFF here, so adding Y wraps past 0xFFFF.
        p = {memf(16'h001E), memf(16'h001D)} + 16'h0020;
        run_case("R8", 4'd8, 16'h001D, 8'h00, 8'h20, p, 1'b0, 4, 2, 16'h001D, 16'h001E);
    endtask

    task automatic t_illegal;
        run_case("R9", 4'd9, 16'h4321, 8'h01, 8'h02, 16'h0000, 1'b1, 1, 0, 0, 0);
        run_case("R9", 4'd15, 16'h4321, 8'h01, 8'h02, 16'h0000, 1'b1, 1, 0, 0, 0);
    endtask

    task automatic t_busy_ignore;
        int lat;
        int dones;
        @(negedge clk);
        mode = 4'd6; operand = 16'h2000; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mode = 4'd0; operand = 16'h4444;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 2;
        while (!done && lat < 20) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        check("R10", "latency", lat, 4);
        check("R10", "address", {16'h0, ea}, {16'h0, memf(16'h2001), memf(16'h2000)});
        dones = 0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (done) dones++;
        end
        check("R10", "extra done", dones, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_absolute();
        t_abs_indexed();
        t_zero_page();
        t_zp_indexed();
        t_indirect();
        t_pre_indexed();
        t_pre_wrap_err();
        t_post_indexed();
        t_illegal();
        t_busy_ignore();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule